// File: doc/BRIEF.md
# Flash program and erase pulse sequencer

This block times the high-voltage pulses that program or bulk-erase a flash array. A command is accepted on `start` together with the operation type and a size/alignment qualifier. The sequencer then repeats one step: it drives `hv_pulse` for a fixed pulse width, keeps it low for a settle delay, and then samples `verify_ok` from the external read-back logic. All durations are counted in clock cycles derived from the `CLK_PER_US` parameter. Programming uses a 22 us pulse with a 10 us settle. Erase uses a 100 us pulse with a 1 us settle.

When verify first passes after n pulses, the block applies n further margin pulses with the same timing and does not sample verify during them. It then raises `done` for one cycle. If the pulse limit is used up without a pass, it raises a sticky `fail` instead. The limit is 50 pulses for programming and 5 for erase. A word-sized program request at an odd address cannot be served: it is refused and a one-cycle `rejected` is reported.

Top module: `flash_pulse_seq`

## Requirements
- R1: While `rst_n` is low and after its release, `hv_pulse`, `busy`, `done`, `fail` and `rejected` are 0.
- R2: An accepted program command (`op_erase`=0) drives `hv_pulse` high from the cycle after `start` for exactly 22*CLK_PER_US cycles per pulse.
- R3: After each program pulse, `hv_pulse` stays low for 10*CLK_PER_US settle cycles plus one check cycle. `verify_ok` is sampled at the clock edge that ends the check cycle.
- R4: An erase command (`op_erase`=1) uses pulses of 100*CLK_PER_US cycles and a settle of 1*CLK_PER_US cycles plus one check cycle. The size and address qualifiers are ignored for erase.
- R5: If verify first passes after n pulses, exactly n margin pulses with the same pulse and settle timing follow, and `verify_ok` is ignored during them.
- R6: In the cycle after the last margin settle cycle, `done` is 1 for exactly one cycle and `busy` is 0.
- R7: A program operation whose check fails after the 50th pulse ends with `busy` 0 and `fail` 1. `fail` stays 1 until the next accepted start clears it.
- R8: An erase operation whose check fails after the 5th pulse ends with `fail` set in the same way.
- R9: A program request with `size_word`=1 and `addr_lsb`=1 is refused. `rejected` is 1 for the following cycle only, no pulse is issued, and `fail` and `done` keep their values. A byte program request (`size_word`=0) is accepted at an odd address.
- R10: A `start` while `busy` is 1 has no effect on the running sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Command strobe, one cycle |
| op_erase | input | 1 | 1 = bulk erase, 0 = program |
| size_word | input | 1 | 1 = 16-bit program, 0 = byte |
| addr_lsb | input | 1 | Least significant bit of the target address |
| verify_ok | input | 1 | Read-back result from the array |
| hv_pulse | output | 1 | High-voltage enable pulse |
| busy | output | 1 | A sequence is running |
| done | output | 1 | One-cycle success indication |
| fail | output | 1 | Sticky pulse-limit failure |
| rejected | output | 1 | One-cycle misaligned-request refusal |

## Verification
Every result of the block is registered, so each one appears in the cycle after the edge that causes it. The first pulse starts one cycle after `start` is sampled. `done`, `fail` and `rejected` appear one cycle after the edge that ends the last settle cycle, the final check cycle, or the command, respectively. The bench builds from the requirements a per-cycle list of expected outputs, together with the `verify_ok` value to drive in each cycle. At every falling edge it drives that cycle's input and compares all outputs with the list, so each result is compared in exactly the cycle it is due.

// File: rtl/flash_pulse_seq.sv
module flash_pulse_seq #(
  parameter int CLK_PER_US       = 2,
  parameter int PROG_PULSE_US    = 22,
  parameter int PROG_SETTLE_US   = 10,
  parameter int PROG_MAX_PULSES  = 50,
  parameter int ERASE_PULSE_US   = 100,
  parameter int ERASE_SETTLE_US  = 1,
  parameter int ERASE_MAX_PULSES = 5
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic op_erase,
  input  logic size_word,
  input  logic addr_lsb,
  input  logic verify_ok,
  output logic hv_pulse,
  output logic busy,
  output logic done,
  output logic fail,
  output logic rejected
);
  localparam int PP = CLK_PER_US * PROG_PULSE_US;
  localparam int PS = CLK_PER_US * PROG_SETTLE_US;
  localparam int EP = CLK_PER_US * ERASE_PULSE_US;
  localparam int ES = CLK_PER_US * ERASE_SETTLE_US;
  localparam int M1 = (PP > PS) ? PP : PS;
  localparam int M2 = (EP > ES) ? EP : ES;
  localparam int TMAX = (M1 > M2) ? M1 : M2;
  localparam int TW = $clog2(TMAX + 1);
  localparam int NMAX = (PROG_MAX_PULSES > ERASE_MAX_PULSES) ? PROG_MAX_PULSES : ERASE_MAX_PULSES;
  localparam int CW = $clog2(NMAX + 1);

  typedef enum logic [2:0] {S_IDLE, S_PULSE, S_SETTLE, S_CHECK, S_MPULSE, S_MSETTLE} st_t;

  st_t st;
  logic [TW-1:0] timer;
  logic [CW-1:0] npulse, left;
  logic is_erase, fail_q, done_q, rej_q;

  wire misaligned = !op_erase && size_word && addr_lsb;
  wire accept     = start && (st == S_IDLE) && !misaligned;
  wire refuse     = start && (st == S_IDLE) && misaligned;

  wire [TW-1:0] pulse_t  = is_erase ? TW'(EP - 1) : TW'(PP - 1);
  wire [TW-1:0] settle_t = is_erase ? TW'(ES - 1) : TW'(PS - 1);
  wire [CW-1:0] max_n    = is_erase ? CW'(ERASE_MAX_PULSES) : CW'(PROG_MAX_PULSES);
  wire tz = (timer == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE;
      timer <= '0;
      npulse <= '0;
      left <= '0;
      is_erase <= 1'b0;
      fail_q <= 1'b0;
      done_q <= 1'b0;
      rej_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      rej_q <= refuse;
      case (st)
        S_IDLE: if (accept) begin
          is_erase <= op_erase;
          fail_q <= 1'b0;
          npulse <= '0;
          timer <= op_erase ? TW'(EP - 1) : TW'(PP - 1);
          st <= S_PULSE;
        end
        S_PULSE: if (tz) begin
          npulse <= npulse + 1'b1;
          timer <= settle_t;
          st <= S_SETTLE;
        end else timer <= timer - 1'b1;
        S_SETTLE: if (tz) st <= S_CHECK;
                  else timer <= timer - 1'b1;
        S_CHECK: if (verify_ok) begin
          left <= npulse;
          timer <= pulse_t;
          st <= S_MPULSE;
        end else if (npulse == max_n) begin
          fail_q <= 1'b1;
          st <= S_IDLE;
        end else begin
          timer <= pulse_t;
          st <= S_PULSE;
        end
        S_MPULSE: if (tz) begin
          left <= left - 1'b1;
          timer <= settle_t;
          st <= S_MSETTLE;
        end else timer <= timer - 1'b1;
        S_MSETTLE: if (tz) begin
          if (left == '0) begin
            done_q <= 1'b1;
            st <= S_IDLE;
          end else begin
            timer <= pulse_t;
            st <= S_MPULSE;
          end
        end else timer <= timer - 1'b1;
        default: st <= S_IDLE;
      endcase
    end
  end

  assign hv_pulse = (st == S_PULSE) || (st == S_MPULSE);
  assign busy     = (st != S_IDLE);
  assign done     = done_q;
  assign fail     = fail_q;
  assign rejected = rej_q;
endmodule

// File: rtl/flash_pulse_seq_chk.sv
module flash_pulse_seq_chk #(
  parameter int PULSE_A = 44,
  parameter int PULSE_B = 200
) (
  input logic clk,
  input logic rst_n,
  input logic start,
  input logic hv_pulse,
  input logic busy,
  input logic done,
  input logic fail,
  input logic rejected
);
  int run;
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) run <= 0;
    else run <= hv_pulse ? run + 1 : 0;

  a_r2_pulse_width: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(hv_pulse) |-> (run == PULSE_A || run == PULSE_B));
  a_r6_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  a_r6_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy && !fail);
  a_r7_fail_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    fail && !start |=> fail);
  a_r7_end_reported: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> (done || fail));
  a_r9_reject_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    rejected |-> !busy && !hv_pulse);
  a_r1_no_pulse_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !hv_pulse);
endmodule

bind flash_pulse_seq flash_pulse_seq_chk #(
  .PULSE_A(CLK_PER_US * PROG_PULSE_US),
  .PULSE_B(CLK_PER_US * ERASE_PULSE_US)
) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .hv_pulse(hv_pulse),
  .busy(busy), .done(done), .fail(fail), .rejected(rejected)
);

// File: tb/flash_pulse_seq_test.sv
module flash_pulse_seq_test;
  localparam int CLK_PERIOD = 10;
  localparam int CPU = 2;
  localparam int PP = CPU * 22, PS = CPU * 10, EP = CPU * 100, ES = CPU * 1;

  logic clk = 0, rst_n = 0, start = 0, op_erase = 0, size_word = 0, addr_lsb = 0, verify_ok = 0;
  logic hv_pulse, busy, done, fail, rejected;

  typedef struct packed { logic hv, bz, dn, fl, rj, ver; } exp_t;
  exp_t q[$];
  int vectors = 0, errors = 0, cycles = 0;
  bit fail_m = 0, finished = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  flash_pulse_seq #(.CLK_PER_US(CPU)) uut (
    .clk(clk), .rst_n(rst_n), .start(start), .op_erase(op_erase),
    .size_word(size_word), .addr_lsb(addr_lsb), .verify_ok(verify_ok),
    .hv_pulse(hv_pulse), .busy(busy), .done(done), .fail(fail), .rejected(rejected));

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000 && !finished) begin
      finished = 1;
      errors++;
      $display("FAIL watchdog: actual running, expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end

  task automatic push(bit hv, bit bz, bit dn, bit fl, bit rj, bit ver, int n);
    exp_t e;
    e = '{hv, bz, dn, fl, rj, ver};
    repeat (n) q.push_back(e);
  endtask

  task automatic cmp(string tag, exp_t e);
    vectors++;
    if ({hv_pulse, busy, done, fail, rejected} !== {e.hv, e.bz, e.dn, e.fl, e.rj}) begin
      errors++;
      $display("FAIL %s: actual hv/busy/done/fail/rej=%b%b%b%b%b expected %b%b%b%b%b",
               tag, hv_pulse, busy, done, fail, rejected, e.hv, e.bz, e.dn, e.fl, e.rj);
    end
  endtask

  task automatic run_op(string tag, bit er, bit wd, bit lsb, int pass_at, bit poke);
    int p, s, mx;
    p = er ? EP : PP;
    s = er ? ES : PS;
    mx = er ? 5 : 50;
    q.delete();
    if (!er && wd && lsb) begin
      push(0, 0, 0, fail_m, 1, 0, 1);
      push(0, 0, 0, fail_m, 0, 0, 3);
    end else begin
      for (int k = 1; k <= mx; k++) begin
        bit ok;
        ok = (pass_at != 0) && (k >= pass_at);
        push(1, 1, 0, 0, 0, 0, p);
        push(0, 1, 0, 0, 0, 0, s);
        push(0, 1, 0, 0, 0, ok, 1);
        if (ok) begin
          for (int j = 0; j < k; j++) begin
            push(1, 1, 0, 0, 0, 0, p);
            push(0, 1, 0, 0, 0, 0, s);
          end
          push(0, 0, 1, 0, 0, 0, 1);
          push(0, 0, 0, 0, 0, 0, 3);
          fail_m = 0;
          break;
        end
        if (k == mx) begin
          fail_m = 1;
          push(0, 0, 0, 1, 0, 0, 4);
        end
      end
    end
    @(negedge clk);
    start = 1; op_erase = er; size_word = wd; addr_lsb = lsb;
    @(negedge clk);
    start = 0;
    for (int i = 0; i < q.size(); i++) begin
      cmp(tag, q[i]);
      verify_ok = q[i].ver;
      if (poke && i == 5) begin start = 1; op_erase = ~er; size_word = 0; end
      if (poke && i == 6) start = 0;
      @(negedge clk);
    end
    verify_ok = 0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    cmp("R1 in reset", '0);
    rst_n = 1;
    @(negedge clk);
    cmp("R1 after reset", '0);
    run_op("R2/R3/R5/R6/R10 prog byte pass3", 0, 0, 0, 3, 1);
    run_op("R2/R5/R6 prog aligned word pass1", 0, 1, 0, 1, 0);
    run_op("R9 prog odd byte accepted", 0, 0, 1, 2, 0);
    run_op("R8 erase never passes", 1, 0, 0, 0, 0);
    run_op("R9 misaligned word refused", 0, 1, 1, 1, 0);
    run_op("R7 prog never passes", 0, 0, 0, 0, 0);
    run_op("R5/R7 prog pass at limit", 0, 1, 0, 50, 0);
    run_op("R4/R5 erase qualifier ignored", 1, 1, 1, 5, 0);
    run_op("R10 erase pass2 with stray start", 1, 0, 0, 2, 1);
    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule